// File: doc/BRIEF.md
# Shared General-Purpose I/O Port with Peripheral Override

This block is a parameterised bank of general-purpose pins. Each pin can be driven either by the port's own registers or by a peripheral that shares the pin. The port keeps a direction register and an output latch. It also samples the pin levels through a two-stage synchronizer. Software reaches all three through single-cycle write and read strobes that share one write-data bus and one read-data bus.

For every bit, a pair of multiplexers decides who drives the pad. The peripheral takes both the data and the output enable, but only while it is enabled and is asserting its own output enable. In every other case the latch and the direction bit control the pin. The value passed back to the peripheral is always the synchronized pad level, never the latch, so port output cannot loop straight into a peripheral input.

A mask parameter marks which bit positions exist. Bits that do not exist ignore writes, read as zero and never drive their pads.

Top module: `shared_gpio_port`

## Requirements
- R1: After reset every implemented direction bit is 1 (input), the latch is all zeros and no pin is driven (`pin_oe` all zeros).
- R2: A `dir_wr` strobe loads `wdata` into the direction register at the next clock edge. `rd_dir` returns the stored bits. For a pin the port owns, direction 0 sets `pin_oe` high and direction 1 sets it low.
- R3: A `lat_wr` strobe loads `wdata` into the latch at the next clock edge, and `rd_lat` returns the latch. For a pin the port owns, `pin_out` equals the latch bit.
- R4: A `port_wr` strobe loads the latch, not the pads. `rd_port` returns the pad level sampled two clock edges earlier.
- R5: Where `periph_en` and `periph_oe` are both 1, `pin_oe` is 1 and `pin_out` equals `periph_do`, whatever the direction and latch bits hold.
- R6: Where `periph_en` is 1 but `periph_oe` is 0, the direction and latch bits control the pin exactly as they do when the peripheral is disabled.
- R7: `rd_port` returns the synchronized pad level even on bits the peripheral currently owns.
- R8: Bits cleared in `IMPL_MASK` ignore writes, read as 0 on all three read paths and `periph_di`, and keep `pin_oe` and `pin_out` at 0.
- R9: `periph_di` is the synchronized pad level (pad sampled two edges earlier), independent of the latch.
- R10: `rdata` is 0 when no read strobe is high. When several read strobes are high, the priority is `rd_port`, then `rd_lat`, then `rd_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_wr | input | 1 | Write strobe for the direction register |
| lat_wr | input | 1 | Write strobe for the latch |
| port_wr | input | 1 | Write strobe for the port address (loads the latch) |
| wdata | input | W | Write data |
| rd_dir | input | 1 | Read select for direction |
| rd_lat | input | 1 | Read select for latch |
| rd_port | input | 1 | Read select for synchronized pad levels |
| rdata | output | W | Read data |
| periph_en | input | W | Per-bit peripheral enable |
| periph_oe | input | W | Per-bit peripheral output enable |
| periph_do | input | W | Per-bit peripheral output data |
| periph_di | output | W | Synchronized pad level to the peripheral |
| pin_in | input | W | Pad input level |
| pin_out | output | W | Pad output data |
| pin_oe | output | W | Pad output enable |

## Verification
Directed steps cover reset, every strobe on its own, and the following cases:
- A write to the port address while the pads hold a different value. This tells "latch loaded" apart from "pads driven".
- A peripheral that is enabled and driving, compared with one that is enabled but silent. This tells an ownership rule that uses only the enable apart from one that uses both the enable and the output enable.
- A latch value that differs from the pad level. This catches a peripheral input fed from the latch instead of the pad.

After the directed steps, seeded random cycles mix all strobes, overlapping read selects and per-bit ownership. These cycles expose wrong read priority, wrong synchronizer depth and leakage onto unimplemented bits.

// File: rtl/shared_gpio_port.sv
module shared_gpio_port #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL_MASK = 8'b0111_1011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_wr,
  input  logic         lat_wr,
  input  logic         port_wr,
  input  logic [W-1:0] wdata,
  input  logic         rd_dir,
  input  logic         rd_lat,
  input  logic         rd_port,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] periph_en,
  input  logic [W-1:0] periph_oe,
  input  logic [W-1:0] periph_do,
  output logic [W-1:0] periph_di,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  logic [W-1:0] dir_q, lat_q, sync1_q, sync2_q, own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= IMPL_MASK;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (dir_wr)            dir_q <= wdata & IMPL_MASK;
      if (lat_wr || port_wr) lat_q <= wdata & IMPL_MASK;
      sync1_q <= pin_in & IMPL_MASK;
      sync2_q <= sync1_q;
    end
  end

  assign own       = periph_en & periph_oe & IMPL_MASK;
  assign pin_oe    = IMPL_MASK & (own | ~dir_q);
  assign pin_out   = IMPL_MASK & ((own & periph_do) | (~own & lat_q));
  assign periph_di = sync2_q;

  always_comb begin
    if (rd_port)     rdata = sync2_q;
    else if (rd_lat) rdata = lat_q;
    else if (rd_dir) rdata = dir_q;
    else             rdata = '0;
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (dir_q == ($past(wdata) & IMPL_MASK)));

  assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_wr || port_wr) |=> (lat_q == ($past(wdata) & IMPL_MASK)));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_wr || port_wr) |=> $stable(lat_q));

  assert_periph_owns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & own) == own) && (((pin_out ^ periph_do) & own) == '0));

  assert_port_controls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_oe ^ ~dir_q) & ~own & IMPL_MASK) == '0) &&
    (((pin_out ^ lat_q) & ~own & IMPL_MASK) == '0));

  assert_unimpl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out | rdata | periph_di) & ~IMPL_MASK) == '0);

  assert_sync_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2) |-> (periph_di == ($past(pin_in, 2) & IMPL_MASK)));

endmodule

// File: tb/tb_shared_gpio_port.sv
module tb_shared_gpio_port;
  localparam int W = 8;
  localparam logic [W-1:0] M = 8'b0111_1011;

  logic clk = 0, rst_n = 0;
  logic dir_wr = 0, lat_wr = 0, port_wr = 0, rd_dir = 0, rd_lat = 0, rd_port = 0;
  logic [W-1:0] wdata = 0, periph_en = 0, periph_oe = 0, periph_do = 0, pin_in = 0;
  logic [W-1:0] rdata, periph_di, pin_out, pin_oe;

  int vectors = 0, errors = 0;
  logic [W-1:0] m_dir, m_lat, m_s1, m_s2;

  always #10 clk = ~clk;

  shared_gpio_port #(.W(W), .IMPL_MASK(M)) dut (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .lat_wr(lat_wr), .port_wr(port_wr),
    .wdata(wdata), .rd_dir(rd_dir), .rd_lat(rd_lat), .rd_port(rd_port), .rdata(rdata),
    .periph_en(periph_en), .periph_oe(periph_oe), .periph_do(periph_do),
    .periph_di(periph_di), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [W-1:0] exp_oe(logic [W-1:0] en, logic [W-1:0] oe);
    logic [W-1:0] own = en & oe & M;
    return M & (own | ~m_dir);
  endfunction

  function automatic logic [W-1:0] exp_out(logic [W-1:0] en, logic [W-1:0] oe, logic [W-1:0] d);
    logic [W-1:0] own = en & oe & M;
    return M & ((own & d) | (~own & m_lat));
  endfunction

  function automatic logic [W-1:0] exp_rd(logic [2:0] rs);
    if (rs[2]) return m_s2;
    if (rs[1]) return m_lat;
    if (rs[0]) return m_dir;
    return '0;
  endfunction

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // wr = {dir,lat,port}; rs = {port,lat,dir}
  task automatic step(string tag, logic [2:0] wr, logic [W-1:0] wd, logic [2:0] rs,
                      logic [W-1:0] pins, logic [W-1:0] en, logic [W-1:0] oe, logic [W-1:0] d);
    @(negedge clk);
    {dir_wr, lat_wr, port_wr} = wr;
    {rd_port, rd_lat, rd_dir} = rs;
    wdata = wd; pin_in = pins; periph_en = en; periph_oe = oe; periph_do = d;
    #1;
    cmp(tag, "pin_oe", pin_oe, exp_oe(en, oe));
    cmp(tag, "pin_out", pin_out, exp_out(en, oe, d));
    cmp(tag, "rdata", rdata, exp_rd(rs));
    cmp(tag, "periph_di", periph_di, m_s2);
    if (wr[2]) m_dir = wd & M;
    if (wr[1] || wr[0]) m_lat = wd & M;
    m_s2 = m_s1;
    m_s1 = pins & M;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    m_dir = M; m_lat = 0; m_s1 = 0; m_s2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step("R1", 3'b000, 8'h00, 3'b001, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R1", 3'b000, 8'h00, 3'b010, 8'h00, 8'h00, 8'h00, 8'h00);
    // R2 direction write, read back, drive
    step("R2", 3'b100, 8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2", 3'b000, 8'h00, 3'b001, 8'h00, 8'h00, 8'h00, 8'h00);
    // R3 latch write and read
    step("R3", 3'b010, 8'hA5, 3'b000, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R3", 3'b000, 8'h00, 3'b010, 8'h00, 8'h00, 8'h00, 8'h00);
    // R4 port write loads latch; port read sees pads two edges later
    step("R4", 3'b001, 8'h3C, 3'b100, 8'h0F, 8'h00, 8'h00, 8'h00);
    step("R4", 3'b000, 8'h00, 3'b010, 8'h0F, 8'h00, 8'h00, 8'h00);
    step("R4", 3'b000, 8'h00, 3'b100, 8'h0F, 8'h00, 8'h00, 8'h00);
    // R5 and R7 peripheral ownership, pad still readable
    step("R5", 3'b000, 8'h00, 3'b100, 8'hC3, 8'hF0, 8'hF0, 8'h55);
    step("R7", 3'b000, 8'h00, 3'b100, 8'hC3, 8'hF0, 8'hF0, 8'h55);
    step("R7", 3'b000, 8'h00, 3'b100, 8'hC3, 8'hF0, 8'hF0, 8'h55);
    // R6 enabled but silent
    step("R6", 3'b000, 8'h00, 3'b000, 8'hC3, 8'hFF, 8'h00, 8'hFF);
    step("R6", 3'b100, 8'hF0, 3'b000, 8'hC3, 8'hFF, 8'h0F, 8'h00);
    step("R6", 3'b000, 8'h00, 3'b001, 8'hC3, 8'hFF, 8'h00, 8'hAA);
    // R8 unimplemented bits
    step("R8", 3'b110, 8'hFF, 3'b000, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    step("R8", 3'b000, 8'h00, 3'b001, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    step("R8", 3'b000, 8'h00, 3'b010, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R8", 3'b000, 8'h00, 3'b100, 8'hFF, 8'h00, 8'h00, 8'h00);
    // R9 peripheral input follows pads, not latch
    step("R9", 3'b010, 8'hFF, 3'b000, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R9", 3'b000, 8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R9", 3'b000, 8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 8'h00);
    // R10 read select priority
    step("R10", 3'b000, 8'h00, 3'b000, 8'h5A, 8'h00, 8'h00, 8'h00);
    step("R10", 3'b000, 8'h00, 3'b111, 8'h5A, 8'h00, 8'h00, 8'h00);
    step("R10", 3'b000, 8'h00, 3'b011, 8'h5A, 8'h00, 8'h00, 8'h00);
    step("R10", 3'b000, 8'h00, 3'b111, 8'h5A, 8'h00, 8'h00, 8'h00);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] wr = 3'($urandom) & 3'($urandom);
      step("random", wr, 8'($urandom), 3'($urandom), 8'($urandom),
           8'($urandom), 8'($urandom), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule